// File: doc/BRIEF.md
# Sigma-Delta Serial Channel Receiver

This block is the bit-recovery front end that sits between the pins of external sigma-delta modulators and a decimation filter. Each of `NUM_CH` channels watches a serial clock pin and a serial data pin. Depending on its line mode, a channel either samples the data on one edge of a chosen clock, or decodes a Manchester-coded data line with no clock. Each recovered bit is handed to the filter as a value plus a one-cycle valid strobe.

The channel's clock can be its own clock pin or a clock the block makes itself. The internal clock has a half period of `CLK_DIV` system cycles, is driven out on `sck_o` so it can feed the modulators, and is also offered at half rate in either polarity. A channel can instead take its clock and data pins from its neighbour, which lets two filters share one modulator stream. A per-channel enable gates everything the channel emits.

Top module: `sdr_rx_front`

## Requirements
- R1: Line mode 0 (`chan_mode_i[2i+1:2i]` = 0) emits exactly one bit per rising edge of the channel's selected clock, with the value the data line held at that edge.
- R2: Line mode 1 emits exactly one bit per falling edge of the selected clock, with the value the data line held at that edge.
- R3: Line modes 2 and 3 decode Manchester data, one bit per bit period of `MAN_BIT` system cycles. In mode 2 a rising mid-bit transition gives 0 and a falling one gives 1. In mode 3 a rising transition gives 1 and a falling one gives 0. Any data transition within `3*MAN_BIT/4` cycles after an accepted transition is ignored as a bit-boundary transition.
- R4: Clock source 0 (`chan_src_i[2i+1:2i]` = 0) uses the channel's clock pin, passed with its data through a two-flop synchroniser. Source 1 uses the internal clock `sck_o`. This clock is low after reset and toggles every `CLK_DIV` cycles, so its period is `2*CLK_DIV` cycles.
- R5: A half-rate clock starts low after reset and toggles on every rising edge of `sck_o`. Source 3 uses it as is, and source 2 uses its inverse. On a half-rate source, the odd-numbered `sck_o` rising edges since reset are rising edges of the half-rate clock.
- R6: With `chan_alt_i[i]` set, channel i takes both its clock and data from pin index (i+1) mod `NUM_CH`. With it clear, the neighbour's pins have no effect on channel i.
- R7: While `chan_en_i[i]` is low, `bit_vld_o[i]` stays low, and the Manchester blanking state is cleared.
- R8: During reset `sck_o`, `bit_o` and `bit_vld_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | NUM_CH | Serial clock pins, one per channel |
| ser_dat_i | input | NUM_CH | Serial data pins, one per channel |
| chan_en_i | input | NUM_CH | Per-channel enable |
| chan_mode_i | input | 2*NUM_CH | Line mode per channel: 0 rising-edge sampled, 1 falling-edge sampled, 2/3 Manchester |
| chan_src_i | input | 2*NUM_CH | Clock source per channel: 0 pin, 1 internal, 2 inverted half-rate, 3 half-rate |
| chan_alt_i | input | NUM_CH | Take the pins of the neighbouring channel |
| sck_o | output | 1 | Internally generated serial clock |
| bit_o | output | NUM_CH | Recovered bit per channel |
| bit_vld_o | output | NUM_CH | One-cycle strobe marking a new bit on bit_o |

## Verification
The embedded properties watch, on every cycle, the internal clock's timing, the nesting of half-rate edges inside internal rising edges, the silence of a disabled channel, and the rule that a Manchester channel never strobes on two cycles in a row. Only the bench's scenarios can show that each bit carries the right value and that no edge is lost or doubled. Those scenarios cover every clock source with both sampling edges, both Manchester polarities with blanked boundary transitions, and the neighbour-pin routing in both settings. The bench compares the whole recovered stream with the stream it drove.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [1:0] {
        MODE_SPI_RISE = 2'd0,
        MODE_SPI_FALL = 2'd1,
        MODE_MAN_R0   = 2'd2,
        MODE_MAN_R1   = 2'd3
    } line_mode_e;

    typedef enum logic [1:0] {
        CK_PIN      = 2'd0,
        CK_INT      = 2'd1,
        CK_HALF_INV = 2'd2,
        CK_HALF     = 2'd3
    } ck_src_e;

    typedef struct packed {
        logic       en;
        line_mode_e mode;
        ck_src_e    src;
        logic       alt;
    } chan_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic is_man(line_mode_e m);
        return (m == MODE_MAN_R0) || (m == MODE_MAN_R1);
    endfunction

    function automatic edge_t pick_edges(ck_src_e s, edge_t pin_e, edge_t int_e, edge_t half_e);
        edge_t r;
        case (s)
            CK_PIN:      r = pin_e;
            CK_INT:      r = int_e;
            CK_HALF_INV: r = '{rise: half_e.fall, fall: half_e.rise};
            default:     r = half_e;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/sdr_clkgen.sv
module sdr_clkgen
    import sdr_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    output logic  sck_o,
    output edge_t int_e,
    output edge_t half_e
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;
    logic          sck;
    logic          half;
    logic          wrap;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sck  <= 1'b0;
            half <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + CW'(1);
            if (wrap) sck <= ~sck;
            if (wrap && !sck) half <= ~half;
        end
    end

    assign sck_o       = sck;
    assign int_e.rise  = wrap & ~sck;
    assign int_e.fall  = wrap & sck;
    assign half_e.rise = int_e.rise & ~half;
    assign half_e.fall = int_e.rise & half;

    // R4: an internal rising event is followed by sck_o high
    a_r4_rise_high: assert property (@(posedge clk) disable iff (rst)
        int_e.rise |=> sck_o);

    // R5: half-rate edges only coincide with internal rising edges
    a_r5_half_subset: assert property (@(posedge clk) disable iff (rst)
        (half_e.rise || half_e.fall) |-> int_e.rise);

    generate
        if (CLK_DIV > 1) begin : g_hold
            // R4: sck_o never toggles on two consecutive cycles
            a_r4_hold: assert property (@(posedge clk) disable iff (rst)
                (sck_o != $past(sck_o)) |=> $stable(sck_o));
        end
    endgenerate
endmodule

// File: rtl/sdr_chan.sv
module sdr_chan
    import sdr_pkg::*;
#(
    parameter int BLANK = 6,
    parameter int BL_W  = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      pin_clk_s,
    input  logic      pin_dat_s,
    input  edge_t     int_e,
    input  edge_t     half_e,
    output logic      bit_o,
    output logic      vld_o
);
    logic            clk_d;
    logic            dat_d;
    logic [BL_W-1:0] blank;
    edge_t           pin_e;
    edge_t           sel_e;
    logic            spi_hit;
    logic            d_rise;
    logic            d_fall;
    logic            man_hit;
    logic            man_val;

    assign pin_e.rise = pin_clk_s & ~clk_d;
    assign pin_e.fall = ~pin_clk_s & clk_d;
    assign sel_e      = pick_edges(cfg.src, pin_e, int_e, half_e);
    assign spi_hit    = (cfg.mode == MODE_SPI_RISE) ? sel_e.rise : sel_e.fall;

    assign d_rise  = pin_dat_s & ~dat_d;
    assign d_fall  = ~pin_dat_s & dat_d;
    assign man_hit = (blank == '0) && (d_rise || d_fall);
    assign man_val = (cfg.mode == MODE_MAN_R0) ? d_fall : d_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d <= 1'b0;
            dat_d <= 1'b0;
            blank <= '0;
            bit_o <= 1'b0;
            vld_o <= 1'b0;
        end else begin
            clk_d <= pin_clk_s;
            dat_d <= pin_dat_s;
            if (!cfg.en) begin
                vld_o <= 1'b0;
                blank <= '0;
            end else if (is_man(cfg.mode)) begin
                vld_o <= man_hit;
                if (man_hit) begin
                    bit_o <= man_val;
                    blank <= BL_W'(BLANK);
                end else if (blank != '0) begin
                    blank <= blank - BL_W'(1);
                end
            end else begin
                vld_o <= spi_hit;
                blank <= '0;
                if (spi_hit) bit_o <= pin_dat_s;
            end
        end
    end

    // R7: a disabled channel emits nothing on the next cycle
    a_r7_gate: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !vld_o);

    // R3: Manchester strobes are never back to back
    a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
        (vld_o && is_man(cfg.mode)) |=> (!vld_o || !is_man(cfg.mode)));
endmodule

// File: rtl/sdr_rx_front.sv
module sdr_rx_front
    import sdr_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int CLK_DIV = 4,
    parameter int MAN_BIT = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     ser_clk_i,
    input  logic [NUM_CH-1:0]     ser_dat_i,
    input  logic [NUM_CH-1:0]     chan_en_i,
    input  logic [2*NUM_CH-1:0]   chan_mode_i,
    input  logic [2*NUM_CH-1:0]   chan_src_i,
    input  logic [NUM_CH-1:0]     chan_alt_i,
    output logic                  sck_o,
    output logic [NUM_CH-1:0]     bit_o,
    output logic [NUM_CH-1:0]     bit_vld_o
);
    localparam int BLANK = (MAN_BIT * 3) / 4;
    localparam int BL_W  = $clog2(BLANK + 1);

    logic [NUM_CH-1:0] clk_s;
    logic [NUM_CH-1:0] dat_s;
    edge_t             int_e;
    edge_t             half_e;

    sdr_sync #(.W(2 * NUM_CH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({ser_clk_i, ser_dat_i}),
        .q_o ({clk_s, dat_s})
    );

    sdr_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .sck_o  (sck_o),
        .int_e  (int_e),
        .half_e (half_e)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            localparam int NB = (ch + 1) % NUM_CH;
            chan_cfg_t cfg;
            logic      pin_clk;
            logic      pin_dat;

            assign cfg = '{en:   chan_en_i[ch],
                           mode: line_mode_e'(chan_mode_i[2*ch +: 2]),
                           src:  ck_src_e'(chan_src_i[2*ch +: 2]),
                           alt:  chan_alt_i[ch]};
            assign pin_clk = cfg.alt ? clk_s[NB] : clk_s[ch];
            assign pin_dat = cfg.alt ? dat_s[NB] : dat_s[ch];

            sdr_chan #(.BLANK(BLANK), .BL_W(BL_W)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .cfg       (cfg),
                .pin_clk_s (pin_clk),
                .pin_dat_s (pin_dat),
                .int_e     (int_e),
                .half_e    (half_e),
                .bit_o     (bit_o[ch]),
                .vld_o     (bit_vld_o[ch])
            );
        end
    endgenerate
endmodule

// File: tb/sdr_rx_front_tb.sv
module sdr_rx_front_tb;
    localparam int NUM_CH   = 2;
    localparam int CLK_DIV  = 4;
    localparam int MAN_BIT  = 8;
    localparam int EXT_HALF = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_CH-1:0]   ser_clk_i = '0;
    logic [NUM_CH-1:0]   ser_dat_i = '0;
    logic [NUM_CH-1:0]   chan_en_i = '0;
    logic [2*NUM_CH-1:0] chan_mode_i = '0;
    logic [2*NUM_CH-1:0] chan_src_i = '0;
    logic [NUM_CH-1:0]   chan_alt_i = '0;
    logic                sck_o;
    logic [NUM_CH-1:0]   bit_o;
    logic [NUM_CH-1:0]   bit_vld_o;

    sdr_rx_front #(.NUM_CH(NUM_CH), .CLK_DIV(CLK_DIV), .MAN_BIT(MAN_BIT)) u_dut (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
        .chan_en_i(chan_en_i), .chan_mode_i(chan_mode_i), .chan_src_i(chan_src_i),
        .chan_alt_i(chan_alt_i), .sck_o(sck_o), .bit_o(bit_o), .bit_vld_o(bit_vld_o)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // stimulus engine state
    int   kind = 0;      // 1 internal clock, 2 pin clock, 3 Manchester
    int   st = 0;        // 0 idle, 1 running, 2 draining
    bit   start_req = 1'b0;
    bit   keep_off = 1'b0;
    int   tch = 0;
    int   mch = 0;
    int   cur_mode = 0;
    int   cur_src = 0;
    int   run_cnt = 0;
    int   drain = 0;
    int   ecnt = 0;
    int   hcnt = 0;
    int   left = 0;
    bit   second = 1'b0;
    logic elvl = 1'b0;
    logic cur_dat = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic sck_prev = 1'b0;
    int   rcnt = 0;
    int   cyc = 0;
    int   last_rise = 0;
    int   sck_per = 0;
    logic r_e, f_e, odd, smp, upd;

    logic exp_q [0:255];
    logic rcv_q [0:255];
    int   ne = 0;
    int   nr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input logic v);
        if (ne < 256) exp_q[ne] = v;
        ne++;
    endtask

    task automatic nxt();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cur_dat = lfsr[0];
    endtask

    function automatic logic man_first(input logic b);
        return (cur_mode == 2) ? b : ~b;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            sck_prev = 1'b0;
            rcnt = 0;
        end else begin
            if (bit_vld_o[mch]) begin
                if (nr < 256) rcv_q[nr] = bit_o[mch];
                nr++;
            end
            r_e = sck_o && !sck_prev;
            f_e = !sck_o && sck_prev;
            sck_prev = sck_o;
            if (r_e) begin
                rcnt++;
                if (last_rise > 0) sck_per = cyc - last_rise;
                last_rise = cyc;
            end
            cyc++;
            if (st == 1) begin
                case (kind)
                    1: begin
                        odd = rcnt[0];
                        if (cur_src == 1) begin
                            smp = (cur_mode == 0) ? r_e : f_e;
                            upd = (cur_mode == 0) ? f_e : r_e;
                        end else if (cur_src == 3) begin
                            smp = r_e && (odd == (cur_mode == 0));
                            upd = r_e && (odd != (cur_mode == 0));
                        end else begin
                            smp = r_e && (odd == (cur_mode == 1));
                            upd = r_e && (odd != (cur_mode == 1));
                        end
                        if (smp) push(cur_dat);
                        if (upd) begin nxt(); ser_dat_i[tch] = cur_dat; end
                        run_cnt--;
                        if (run_cnt == 0) begin st = 0; chan_en_i = '0; end
                    end
                    2: begin
                        ecnt++;
                        if (ecnt == EXT_HALF) begin
                            ecnt = 0;
                            elvl = ~elvl;
                            ser_clk_i[tch] = elvl;
                            if (elvl == (cur_mode == 0)) push(cur_dat);
                            else begin nxt(); ser_dat_i[tch] = cur_dat; end
                        end
                        run_cnt--;
                        if (run_cnt == 0) begin st = 2; drain = 8; end
                    end
                    default: begin
                        hcnt++;
                        if (hcnt == MAN_BIT / 2) begin
                            hcnt = 0;
                            if (second) begin
                                ser_dat_i[tch] = ~ser_dat_i[tch];
                                second = 1'b0;
                                left--;
                            end else if (left == 0) begin
                                st = 2;
                                drain = 8;
                            end else begin
                                nxt();
                                push(cur_dat);
                                ser_dat_i[tch] = man_first(cur_dat);
                                second = 1'b1;
                            end
                        end
                    end
                endcase
            end else if (st == 2) begin
                drain--;
                if (drain == 0) begin st = 0; chan_en_i = '0; end
            end
            if (start_req) begin
                start_req = 1'b0;
                st = 1;
                if (!keep_off) chan_en_i[mch] = 1'b1;
                if (kind == 3) begin
                    push(cur_dat);
                    hcnt = 0;
                    second = 1'b1;
                end
            end
        end
    end

    task automatic at_pos();
        @(posedge clk);
        #1;
    endtask

    // prepare one scenario, run it, wait for the engine to go idle
    task automatic run(input int k, input int m, input int s, input int alt,
                       input int drive_ch, input int mon_ch, input int len, input bit off);
        at_pos();
        chan_en_i = '0;
        chan_alt_i = '0;
        kind = k; cur_mode = m; cur_src = s; tch = drive_ch; mch = mon_ch;
        keep_off = off; run_cnt = len; left = len;
        chan_mode_i[2*mon_ch +: 2] = 2'(m);
        chan_src_i[2*mon_ch +: 2] = 2'(s);
        chan_alt_i[mon_ch] = 1'(alt);
        ser_clk_i = '0;
        ser_dat_i = '0;
        elvl = 1'b0;
        ecnt = 0;
        nxt();
        ser_dat_i[drive_ch] = (k == 3) ? man_first(cur_dat) : cur_dat;
        repeat (12) at_pos();
        ne = 0;
        nr = 0;
        start_req = 1'b1;
        at_pos();
        while (start_req || st != 0) at_pos();
        repeat (4) at_pos();
    endtask

    task automatic compare(input string req);
        int bad = -1;
        chk(ne == nr && ne >= 4, req, nr, ne);
        for (int i = 0; i < ne && i < 256; i++)
            if (bad < 0 && exp_q[i] !== rcv_q[i]) bad = i;
        chk(bad < 0, req, (bad < 0) ? 0 : int'(rcv_q[bad]), (bad < 0) ? 0 : int'(exp_q[bad]));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(sck_o == 1'b0, "R8 sck_o", int'(sck_o), 0);
        chk(bit_o == '0, "R8 bit_o", int'(bit_o), 0);
        chk(bit_vld_o == '0, "R8 bit_vld_o", int'(bit_vld_o), 0);
        at_pos();
        rst = 1'b0;

        // internal and half-rate clocks, both sampling edges: R1 R2 R4 R5
        for (int s = 1; s <= 3; s++) begin
            for (int m = 0; m <= 1; m++) begin
                run(1, m, s, 0, 0, 0, 400, 1'b0);
                compare((m == 0) ? ((s == 1) ? "R1 R4 int" : "R1 R5 half")
                                 : ((s == 1) ? "R2 R4 int" : "R2 R5 half"));
            end
        end
        // R4: internal clock period
        chk(sck_per == 2 * CLK_DIV, "R4 period", sck_per, 2 * CLK_DIV);

        // pin clock through the synchroniser: R4 with R1 and R2
        run(2, 0, 0, 0, 0, 0, 300, 1'b0);
        compare("R1 R4 pin");
        run(2, 1, 0, 0, 0, 0, 300, 1'b0);
        compare("R2 R4 pin");

        // Manchester in both polarities: R3
        run(3, 2, 0, 0, 0, 0, 24, 1'b0);
        compare("R3 mode2");
        run(3, 3, 0, 0, 0, 0, 24, 1'b0);
        compare("R3 mode3");

        // neighbour pins: R6
        run(2, 0, 0, 1, 1, 0, 300, 1'b0);
        compare("R6 alt on");
        run(2, 0, 0, 0, 1, 0, 300, 1'b0);
        chk(nr == 0 && ne > 0, "R6 alt off", nr, 0);

        // second channel on its own pins
        run(1, 1, 1, 0, 1, 1, 300, 1'b0);
        compare("R2 ch1");

        // disabled channel stays silent: R7
        run(1, 0, 1, 0, 0, 0, 300, 1'b1);
        chk(nr == 0 && ne > 0, "R7 disabled", nr, 0);
        run(3, 2, 0, 0, 0, 0, 16, 1'b1);
        chk(nr == 0 && ne > 0, "R7 disabled man", nr, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule